// File: doc/BRIEF.md
# Low-Power State Entry Sequencer

This block decides which reduced-power state a processor core enters and then holds that state. The core pulses a strobe when it executes a wait-for-interrupt or wait-for-event instruction. A deep-sleep bit from the core's own control register takes part in the choice, and so do two request bits in a small local power register. The block then gates the core clock and raises one enable for the chosen state. Downstream logic uses those enables to switch analog supplies, oscillators and the PLL.

Each state that is actually entered leaves a sticky flag in the same register. Software can therefore tell after wake-up where the core has been. Any pending interrupt that is enabled brings the core back to run mode. Peripheral clocks are not touched, so peripherals and DMA can keep running and raise that interrupt.

Top module: `lpm_ctrl`

## Requirements
- R1: While running, the core clock gate `core_clk_en` stays high in every cycle in which `wait_req` is low.
- R2: The state is chosen with this priority: register bit 1 (deep power-down request) first, then register bit 0 (power-down request), then `deep_sel` high (deep sleep), and otherwise plain sleep.
- R3: When `wait_req` is high while running and no enabled interrupt is pending, the outputs change at the next clock edge. `core_clk_en` goes low and only the enable of the chosen state goes high. Plain sleep raises none of the three enables.
- R4: Entering a state sets its flag in `reg_rdata`. Bit 4 is sleep, bit 5 is deep sleep, bit 6 is power-down and bit 7 is deep power-down. Flags of earlier entries are kept.
- R5: A flag clears only when a register write carries a 1 in that bit position, or on reset. Writing 0 to a flag bit has no effect.
- R6: When `wait_req` arrives while an enabled interrupt is pending, the core keeps running, no enable rises and no flag is set.
- R7: While in a low-power state, a pending interrupt whose enable bit is set makes the next clock edge raise `core_clk_en` and drop all state enables. A pending interrupt that is not enabled does nothing.
- R8: After reset, `core_clk_en` is high, all state enables are low and `reg_rdata` reads 0.
- R9: Register bits 1:0 can be written and read back. Bits 3:2 always read 0.
- R10: A `wait_req` pulse that arrives while already in a low-power state changes neither the clock gate nor the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Active-low power-on reset |
| wait_req | input | 1 | One-cycle strobe: a wait instruction has executed |
| deep_sel | input | 1 | Core-side deep-sleep select |
| irq_pend | input | NUM_IRQ | Pending interrupt lines |
| irq_en | input | NUM_IRQ | Per-line interrupt enables |
| reg_wr | input | 1 | Power register write strobe |
| reg_wdata | input | 8 | Write data: bits 1:0 are requests, bits 7:4 are write-1-to-clear |
| reg_rdata | output | 8 | Flags in bits 7:4, requests in bits 1:0 |
| core_clk_en | output | 1 | Core clock gate, high while running |
| deep_sleep_en | output | 1 | Deep-sleep enable |
| pwr_down_en | output | 1 | Power-down enable |
| deep_pwr_down_en | output | 1 | Deep power-down enable |

## Verification
The bench builds the block with NUM_IRQ set to 4. With that width, a single enabled line, a pending but masked line and a fully masked vector can each be driven on purpose. The vector table walks all eight combinations of the two request bits and the deep-sleep select. That brings every priority collision within reach, including both requests set at once. Directed tests then cover an interrupt pending at the moment of entry, a repeated wait strobe while asleep, and the way the sticky flags accumulate and clear.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wait_req,
  input  logic               deep_sel,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               reg_wr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               core_clk_en,
  output logic               deep_sleep_en,
  output logic               pwr_down_en,
  output logic               deep_pwr_down_en
);

  logic       wake;
  logic       enter;
  logic       asleep_q;
  logic [1:0] req_q;
  logic [2:0] en_q;
  logic [3:0] flag_q;
  logic [3:0] pick;

  assign wake  = |(irq_pend & irq_en);
  assign enter = !asleep_q && wait_req && !wake;

  always_comb begin
    if (req_q[1])      pick = 4'b1000;
    else if (req_q[0]) pick = 4'b0100;
    else if (deep_sel) pick = 4'b0010;
    else               pick = 4'b0001;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q <= 1'b0;
      en_q     <= '0;
      req_q    <= '0;
      flag_q   <= '0;
    end else begin
      if (enter) begin
        asleep_q <= 1'b1;
        en_q     <= pick[3:1];
      end else if (asleep_q && wake) begin
        asleep_q <= 1'b0;
        en_q     <= '0;
      end
      if (reg_wr) req_q <= reg_wdata[1:0];
      flag_q <= (flag_q & ~(reg_wr ? reg_wdata[7:4] : 4'b0000))
              | (enter ? pick : 4'b0000);
    end
  end

  assign core_clk_en      = !asleep_q;
  assign deep_sleep_en    = en_q[0];
  assign pwr_down_en      = en_q[1];
  assign deep_pwr_down_en = en_q[2];
  assign reg_rdata        = {flag_q, 2'b00, req_q};

  // R1
  run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en && !wait_req |=> core_clk_en);

  // R2
  dpd_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en && wait_req && !wake && reg_rdata[1] |=> deep_pwr_down_en);

  // R3
  one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({deep_sleep_en, pwr_down_en, deep_pwr_down_en}));

  // R5
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ((reg_rdata[7:4] & $past(reg_rdata[7:4])) == $past(reg_rdata[7:4])));

  // R6
  pending_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en && wake |=> core_clk_en);

  // R7
  wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en && wake |=> core_clk_en && !deep_sleep_en && !pwr_down_en && !deep_pwr_down_en);

  // R10
  asleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en && !wake |=> !core_clk_en && $stable({deep_sleep_en, pwr_down_en, deep_pwr_down_en}));

endmodule

// File: tb/lpm_ctrl_test.sv
`timescale 1ns/1ps
module lpm_ctrl_test;
  localparam int NI = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wait_req = 1'b0;
  logic          deep_sel = 1'b0;
  logic [NI-1:0] irq_pend = '0;
  logic [NI-1:0] irq_en = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          core_clk_en, deep_sleep_en, pwr_down_en, deep_pwr_down_en;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  lpm_ctrl #(.NUM_IRQ(NI)) uut (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .deep_sel(deep_sel),
    .irq_pend(irq_pend), .irq_en(irq_en), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .core_clk_en(core_clk_en), .deep_sleep_en(deep_sleep_en),
    .pwr_down_en(pwr_down_en), .deep_pwr_down_en(deep_pwr_down_en));

  always #2.5 clk = ~clk;

  // {dpd_req, pd_req, deep_sel, exp {dpd,pd,ds} enables, exp flags[7:4]}
  localparam logic [9:0] VEC [8] = '{
    10'b000_000_0001, 10'b001_001_0010, 10'b010_010_0100, 10'b011_010_0100,
    10'b100_100_1000, 10'b101_100_1000, 10'b110_100_1000, 10'b111_100_1000};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_wait();
    wait_req = 1'b1;
    step();
    wait_req = 1'b0;
  endtask

  function automatic logic [3:0] outs();
    return {core_clk_en, deep_pwr_down_en, pwr_down_en, deep_sleep_en};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(); step();
    check("R8 reset outputs", outs(), 4'b1000);
    check("R8 reset register", reg_rdata, 8'h00);
    rst_n = 1'b1;
    step();

    wr(8'h03);
    check("R9 request readback", reg_rdata, 8'h03);
    wr(8'h0E);
    check("R9 bits 3:2 read zero", reg_rdata, 8'h02);
    wr(8'h00);

    for (int i = 0; i < 8; i++) begin
      wr({4'hF, 2'b00, VEC[i][9:8]});
      deep_sel = VEC[i][7];
      pulse_wait();
      check("R3 clock gated with chosen enable", outs(), {1'b0, VEC[i][6:4]});
      check("R2 state priority", {deep_pwr_down_en, pwr_down_en, deep_sleep_en}, VEC[i][6:4]);
      check("R4 entry flag", reg_rdata[7:4], VEC[i][3:0]);
      irq_pend = 4'b0100; irq_en = 4'b1011;
      step();
      check("R7 masked interrupt ignored", outs(), {1'b0, VEC[i][6:4]});
      pulse_wait();
      check("R10 wait while asleep ignored", outs(), {1'b0, VEC[i][6:4]});
      irq_en = 4'b0100;
      step();
      check("R7 wake releases clock", outs(), 4'b1000);
      irq_pend = '0; irq_en = '0; deep_sel = 1'b0;
      step();
    end

    wr(8'hF0);
    for (int k = 0; k < 5; k++) step();
    check("R1 idle keeps clock", outs(), 4'b1000);

    irq_pend = 4'b0001; irq_en = 4'b0001;
    pulse_wait();
    check("R6 pending interrupt aborts entry", outs(), 4'b1000);
    check("R6 no flag on abort", reg_rdata, 8'h00);
    irq_pend = '0; irq_en = '0;
    step();

    pulse_wait();
    irq_pend = 4'b1000; irq_en = 4'b1000; step();
    irq_pend = '0; irq_en = '0;
    deep_sel = 1'b1;
    pulse_wait();
    deep_sel = 1'b0;
    check("R4 flags accumulate", reg_rdata[7:4], 4'b0011);
    irq_pend = 4'b0010; irq_en = 4'b0010; step();
    irq_pend = '0; irq_en = '0;
    wr(8'h00);
    check("R5 zero write keeps flags", reg_rdata[7:4], 4'b0011);
    wr(8'h10);
    check("R5 one clears only its flag", reg_rdata[7:4], 4'b0010);
    step(); step();
    check("R5 flag persists", reg_rdata[7:4], 4'b0010);

    finish_run();
  end
endmodule